// File: doc/BRIEF.md
# Mode-Dependent Receiver Gate Controller

This block opens and closes the receiver video window of a transponder test set. A decode-enable strobe opens the window and arms a line-drive flag. While the flag is set, framing (F1) and interrogation/reply (I/P) strobes pass through as one-cycle line-drive pulses. Each line-drive pulse clears the flag and starts a delay counter. The counter replaces an analog delay line and produces a one-cycle timing pulse 22 µs later (M1) in every mode except mode C, and 25 µs later (M3) in mode C. Delays are counted in clock cycles using a cycles-per-microsecond parameter.

The end of an M1 pulse re-arms the line-drive flag and advances a 2-bit train counter. Each test selection defines its own close condition. The window closes only when that condition falls from high to low. A rising condition does nothing. System tests close when the flag is re-armed. Identity tests close on the I/P pulse that follows the first re-arm. Mode 1 identity closes after two counted trains. Emergency closes after four. Mode C closes at the end of M3.

Top module: `rxGateCtrl`

## Requirements
- R1: A decode-enable strobe in cycle t sets videoEn, sets the line-drive flag and clears trainCount, all visible from cycle t+1. It also re-arms the edge detector, so the close condition cannot fall in cycle t+1.
- R2: An F1 or I/P strobe in cycle t, while the flag is set, gives lineDrive high for exactly cycle t+1 and clears the flag. A strobe while the flag is clear gives no lineDrive pulse.
- R3: timingPulse is high for one cycle, D cycles after the lineDrive cycle. D is 22·CYCLES_PER_US when testSel is not 3'd4, and 25·CYCLES_PER_US when testSel is 3'd4 (mode C).
- R4: Outside mode C, at the end of a timingPulse cycle the flag is set and trainCount advances by one, wrapping from 3 to 0.
- R5: videoEn clears at the end of the cycle in which the selected close condition is low after being high in the previous cycle.
- R6: System test (testSel 3'd0, and the unused codes 3'd5 to 3'd7): the close condition is the flag being clear. The gate-open length is a+2+D for a first strobe in cycle a.
- R7: Identity (testSel 3'd1): the close condition is the flag being set together with trainCount bit 0. A later strobe that clears the flag closes the gate, so a close strobe in cycle b gives an open length of b+1.
- R8: Mode 1 identity (testSel 3'd2): the close condition is trainCount equal to 1, so the gate closes at the second count (length b+2+D). trainCount then reads 2.
- R9: Emergency (testSel 3'd3): the close condition is trainCount equal to 3, so the gate closes at the fourth count. trainCount then reads 0.
- R10: Mode C (testSel 3'd4): the close condition is timingPulse (M3), and the gate-open length is a+2+D. M3 sets neither the flag nor the counter, so a later I/P strobe gives no lineDrive.
- R11: A rise of the close condition while videoEn is high leaves videoEn high.
- R12: A new lineDrive pulse while a delay is running restarts the delay from that pulse.
- R13: A synchronous reset clears videoEn, lineDrive, timingPulse, trainCount, the flag and the delay counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decodeEn | input | 1 | Decode-enable strobe; opens the gate |
| f1Pulse | input | 1 | Framing pulse strobe |
| ipPulse | input | 1 | Interrogation/reply pulse strobe |
| testSel | input | 3 | 0 system, 1 identity, 2 mode 1 identity, 3 emergency, 4 mode C |
| lineDrive | output | 1 | Gated line-drive pulse |
| timingPulse | output | 1 | Delayed timing pulse (M1 or M3) |
| videoEn | output | 1 | Receiver video gate window |
| trainCount | output | 2 | Count of completed M1 pulses |

## Verification
The bench builds the block with CYCLES_PER_US set to 2, which gives an M1 delay of 44 cycles and an M3 delay of 50 cycles. At these values all five close rules, including the four-train emergency sequence, finish within a few hundred cycles. Strobes are spaced at the nominal 24 µs (48 cycles), just beyond the M1 re-arm point, so each train is counted. The short delays also let a second decode-enable fall inside a running delay, which exercises the restart rule.

// File: rtl/rxgate_pkg.sv
package rxgate_pkg;

  typedef enum logic [2:0] {
    SEL_SYSTEM   = 3'd0,
    SEL_IDENTITY = 3'd1,
    SEL_MODE1    = 3'd2,
    SEL_EMERG    = 3'd3,
    SEL_MODEC    = 3'd4
  } testSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic startDelay;  // line-drive pulse: (re)load the delay counter
    logic longDelay;   // select the mode C delay
  } delayCtl_t;

endpackage

// File: rtl/rxgate_delay.sv
module rxgate_delay
  import rxgate_pkg::*;
#(
  parameter int SHORT_CYCLES = 220,
  parameter int LONG_CYCLES  = 250
) (
  input  logic      clk,
  input  logic      rst,
  input  delayCtl_t ctl,
  output logic      tmPulse
);
  localparam int MAX_CYCLES = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int TW = $clog2(MAX_CYCLES + 1);
  localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_CYCLES - 1);
  localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_CYCLES - 1);

  logic [TW-1:0] remain;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (ctl.startDelay) begin
      running <= 1'b1;
      remain  <= ctl.longDelay ? LONG_LOAD : SHORT_LOAD;
    end else if (running) begin
      if (remain == '0) running <= 1'b0;
      else              remain  <= remain - 1'b1;
    end
  end

  assign tmPulse = running && (remain == '0);

  // R3: the timing pulse lasts one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tmPulse |=> !tmPulse);

  // R12: a restart pushes the pulse out by a full delay
  a_r12_restart: assert property (@(posedge clk) disable iff (rst)
    ctl.startDelay |=> !tmPulse);

endmodule

// File: rtl/rxgate_ctrl.sv
module rxgate_ctrl
  import rxgate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       decodeEn,
  input  logic       f1Pulse,
  input  logic       ipPulse,
  input  logic [2:0] testSel,
  input  logic       tmPulse,
  output delayCtl_t  ctl,
  output logic       lineDrive,
  output logic       videoEn,
  output logic [1:0] trainCount
);
  testSel_e   sel;
  logic       ldEnable;
  logic       ldPulse;
  logic [1:0] trainCnt;
  logic       condPrev;
  logic       isModeC;
  logic       gatedStrobe;
  logic       m1End;
  logic       closeCond;
  logic       condFall;

  assign sel         = testSel_e'(testSel);
  assign isModeC     = (sel == SEL_MODEC);
  assign gatedStrobe = ldEnable && (f1Pulse || ipPulse);
  assign m1End       = tmPulse && !isModeC;

  // Close condition, one per test selection
  always_comb begin
    case (sel)
      SEL_IDENTITY: closeCond = ldEnable && trainCnt[0];
      SEL_MODE1:    closeCond = (trainCnt == 2'd1);
      SEL_EMERG:    closeCond = (trainCnt == 2'd3);
      SEL_MODEC:    closeCond = tmPulse;
      default:      closeCond = !ldEnable;
    endcase
  end

  assign condFall = condPrev && !closeCond;

  // Line-drive enable flag
  always_ff @(posedge clk) begin
    if (rst)                      ldEnable <= 1'b0;
    else if (decodeEn || m1End)   ldEnable <= 1'b1;
    else if (gatedStrobe)         ldEnable <= 1'b0;
  end

  // Registered line-drive pulse
  always_ff @(posedge clk) begin
    if (rst) ldPulse <= 1'b0;
    else     ldPulse <= gatedStrobe;
  end

  // Train counter
  always_ff @(posedge clk) begin
    if (rst)           trainCnt <= '0;
    else if (decodeEn) trainCnt <= '0;
    else if (m1End)    trainCnt <= trainCnt + 2'd1;
  end

  // Falling-edge detector, re-armed by decode-enable
  always_ff @(posedge clk) begin
    if (rst)           condPrev <= 1'b0;
    else if (decodeEn) condPrev <= 1'b0;
    else               condPrev <= closeCond;
  end

  // Video gate window
  always_ff @(posedge clk) begin
    if (rst)           videoEn <= 1'b0;
    else if (decodeEn) videoEn <= 1'b1;
    else if (condFall) videoEn <= 1'b0;
  end

  assign ctl.startDelay = ldPulse;
  assign ctl.longDelay  = isModeC;
  assign lineDrive      = ldPulse;
  assign trainCount     = trainCnt;

  // R1: decode-enable opens the gate and arms the flag
  a_r1_decode_opens: assert property (@(posedge clk) disable iff (rst)
    decodeEn |=> (videoEn && ldEnable && trainCnt == 2'd0));

  // R2: a passed strobe clears the flag and emits one line-drive pulse
  a_r2_strobe_clears: assert property (@(posedge clk) disable iff (rst)
    (gatedStrobe && !decodeEn && !m1End) |=> (!ldEnable && lineDrive));

  // R4: end of M1 re-arms the flag and steps the counter
  a_r4_m1_counts: assert property (@(posedge clk) disable iff (rst)
    (tmPulse && !isModeC && !decodeEn) |=> (ldEnable && trainCnt == $past(trainCnt) + 2'd1));

  // R10: M3 touches neither the counter nor the flag
  a_r10_m3_inert: assert property (@(posedge clk) disable iff (rst)
    (tmPulse && isModeC && !decodeEn && !ldEnable) |=> ($stable(trainCnt) && !ldEnable));

  // R11: a rising close condition never closes the gate
  a_r11_rise_harmless: assert property (@(posedge clk) disable iff (rst)
    (videoEn && $rose(closeCond)) |=> videoEn);

endmodule

// File: rtl/rxGateCtrl.sv
module rxGateCtrl
  import rxgate_pkg::*;
#(
  parameter int CYCLES_PER_US = 10,
  parameter int M1_DELAY_US   = 22,
  parameter int M3_DELAY_US   = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       decodeEn,
  input  logic       f1Pulse,
  input  logic       ipPulse,
  input  logic [2:0] testSel,
  output logic       lineDrive,
  output logic       timingPulse,
  output logic       videoEn,
  output logic [1:0] trainCount
);
  localparam int M1_CYCLES = M1_DELAY_US * CYCLES_PER_US;
  localparam int M3_CYCLES = M3_DELAY_US * CYCLES_PER_US;

  delayCtl_t delayCtl;
  logic      tmPulse;

  rxgate_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .decodeEn   (decodeEn),
    .f1Pulse    (f1Pulse),
    .ipPulse    (ipPulse),
    .testSel    (testSel),
    .tmPulse    (tmPulse),
    .ctl        (delayCtl),
    .lineDrive  (lineDrive),
    .videoEn    (videoEn),
    .trainCount (trainCount)
  );

  rxgate_delay #(
    .SHORT_CYCLES (M1_CYCLES),
    .LONG_CYCLES  (M3_CYCLES)
  ) i_delay (
    .clk     (clk),
    .rst     (rst),
    .ctl     (delayCtl),
    .tmPulse (tmPulse)
  );

  assign timingPulse = tmPulse;

endmodule

// File: tb/test_rxGateCtrl.sv
`timescale 1ns/100ps
module test_rxGateCtrl;
  localparam int CPU = 2;
  localparam int D1  = 22 * CPU;
  localparam int DC  = 25 * CPU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       decodeEn = 1'b0;
  logic       f1Pulse = 1'b0;
  logic       ipPulse = 1'b0;
  logic [2:0] testSel = 3'd0;
  logic       lineDrive, timingPulse, videoEn;
  logic [1:0] trainCount;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  int runLen = 0;
  bit done = 1'b0;

  typedef struct {
    int    len;
    string tag;
  } expGate_t;
  expGate_t expQ[$];
  expGate_t e;

  always #2.5 clk = ~clk;

  rxGateCtrl #(.CYCLES_PER_US(CPU)) i_rxGateCtrl (
    .clk         (clk),
    .rst         (rst),
    .decodeEn    (decodeEn),
    .f1Pulse     (f1Pulse),
    .ipPulse     (ipPulse),
    .testSel     (testSel),
    .lineDrive   (lineDrive),
    .timingPulse (timingPulse),
    .videoEn     (videoEn),
    .trainCount  (trainCount)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, cur);
    end
  endtask

  task automatic stepTo(input int t);
    while (cur < t) begin
      @(negedge clk);
      cur++;
    end
  endtask

  task automatic startGate(input logic [2:0] sel, input int len, input string tag);
    expGate_t g;
    g.len = len;
    g.tag = tag;
    expQ.push_back(g);
    @(negedge clk);
    testSel  = sel;
    decodeEn = 1'b1;
    cur      = 0;
    stepTo(1);
    decodeEn = 1'b0;
  endtask

  task automatic strobeF1(input int t);
    stepTo(t);
    f1Pulse = 1'b1;
    stepTo(t + 1);
    f1Pulse = 1'b0;
  endtask

  task automatic strobeIp(input int t);
    stepTo(t);
    ipPulse = 1'b1;
    stepTo(t + 1);
    ipPulse = 1'b0;
  endtask

  // Monitor: measure each gate window and compare with the queued expectation
  always @(negedge clk) begin
    if (!rst) begin
      if (videoEn) runLen++;
      else if (runLen > 0) begin
        if (expQ.size() == 0) chk(1'b0, "R5 unexpected gate", runLen, 0);
        else begin
          e = expQ.pop_front();
          chk(runLen == e.len, e.tag, runLen, e.len);
        end
        runLen = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R13: reset state
    chk(videoEn == 1'b0 && lineDrive == 1'b0, "R13 reset outputs", {videoEn, lineDrive}, 0);
    chk(trainCount == 2'd0 && timingPulse == 1'b0, "R13 reset count", trainCount, 0);
    rst = 1'b0;

    // R2: strobes before any decode-enable are blocked
    @(negedge clk);
    f1Pulse = 1'b1;
    ipPulse = 1'b1;
    @(negedge clk);
    f1Pulse = 1'b0;
    ipPulse = 1'b0;
    chk(lineDrive == 1'b0, "R2 blocked strobe", lineDrive, 0);
    @(negedge clk);
    chk(lineDrive == 1'b0 && videoEn == 1'b0, "R2 blocked strobe later", lineDrive, 0);

    // System test: R1, R2, R3, R4, R6, R11
    startGate(3'd0, 3 + 2 + D1, "R6 system gate length");
    chk(videoEn == 1'b1, "R1 gate opens", videoEn, 1);
    strobeF1(3);
    chk(lineDrive == 1'b1, "R2 line drive pulse", lineDrive, 1);
    stepTo(5);
    chk(lineDrive == 1'b0, "R2 line drive one cycle", lineDrive, 0);
    chk(videoEn == 1'b1, "R11 rising condition ignored", videoEn, 1);
    stepTo(4 + D1 - 1);
    chk(timingPulse == 1'b0, "R3 M1 not early", timingPulse, 0);
    stepTo(4 + D1);
    chk(timingPulse == 1'b1, "R3 M1 timing", timingPulse, 1);
    stepTo(5 + D1);
    chk(trainCount == 2'd1, "R4 count step", trainCount, 1);
    stepTo(D1 + 20);

    // Identity: R7
    startGate(3'd1, 52, "R7 identity gate length");
    strobeF1(3);
    strobeIp(51);
    stepTo(60);
    chk(trainCount == 2'd1, "R7 identity count", trainCount, 1);

    // Mode 1 identity: R8
    startGate(3'd2, 51 + 2 + D1, "R8 mode1 gate length");
    strobeF1(3);
    strobeIp(51);
    stepTo(51 + D1 + 10);
    chk(trainCount == 2'd2, "R8 mode1 count", trainCount, 2);

    // Emergency: R9
    startGate(3'd3, 147 + 2 + D1, "R9 emergency gate length");
    strobeF1(3);
    strobeIp(51);
    strobeF1(99);
    strobeIp(147);
    stepTo(147 + D1 + 10);
    chk(trainCount == 2'd0, "R9 emergency count wraps", trainCount, 0);

    // Mode C: R3, R10
    startGate(3'd4, 3 + 2 + DC, "R10 mode C gate length");
    strobeF1(3);
    stepTo(4 + D1);
    chk(timingPulse == 1'b0, "R3 no M1 in mode C", timingPulse, 0);
    stepTo(4 + DC);
    chk(timingPulse == 1'b1, "R3 M3 timing", timingPulse, 1);
    strobeIp(4 + DC + 4);
    chk(lineDrive == 1'b0, "R10 I/P blocked after M3", lineDrive, 0);
    chk(trainCount == 2'd0, "R10 M3 does not count", trainCount, 0);
    stepTo(DC + 20);

    // Restart: R12 (system test, second decode-enable inside a running delay)
    startGate(3'd0, 17 + D1, "R12 restart gate length");
    strobeF1(5);
    stepTo(10);
    decodeEn = 1'b1;
    stepTo(11);
    decodeEn = 1'b0;
    strobeF1(15);
    stepTo(6 + D1);
    chk(timingPulse == 1'b0, "R12 old delay cancelled", timingPulse, 0);
    stepTo(16 + D1);
    chk(timingPulse == 1'b1, "R12 restarted delay", timingPulse, 1);
    stepTo(D1 + 30);

    // R13: reset during an open gate
    startGate(3'd0, 4, "R13 gate cut by reset");
    stepTo(3);
    rst = 1'b1;
    stepTo(4);
    rst = 1'b0;
    chk(videoEn == 1'b0, "R13 reset closes gate", videoEn, 0);
    runLen = 0;
    void'(expQ.pop_front());
    stepTo(8);

    chk(expQ.size() == 0, "R5 all gates closed", expQ.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule